// File: doc/BRIEF.md
# Floppy Multi-Sector Transfer Sequencer

This block tracks the disk position while a floppy controller runs a read-data or write-data command. A command is taken in one cycle. Its fields are:

- the multi-track flag;
- the expected cylinder, start head, start sector (1-based), size code and last sector of the track (end-of-track);
- the medium's sectors per track.

The block compares the drive's present cylinder with the expected one. If they differ, the command fails at once. Otherwise the block raises a transfer request. It then steps sector, head and cylinder on each sector-done strobe, which stands in for the data path. It also decides when the transfer ends.

When the command ends, the block pulses a done flag. If the digital-output register's DMA/IRQ enable is set, it also raises an interrupt. It then presents seven result bytes, one at a time, on a valid/ready handshake. The interrupt falls when the last byte is taken. Positions are 0-based inside the block and 1-based in the command and result fields.

Top module: `fdc_xfer_seq`

## Requirements
- R1: After reset the block is idle. busy, xfer_req, done, irq and res_valid are all 0.
- R2: If drive_cyl differs from cmd_cyl when a command is taken, no transfer is requested. The result phase starts in the next cycle, and its first byte (status 0) has bit 6 set and the start head in bit 2.
- R3: With cmd_mt = 0 the transfer ends after one sector-done strobe. The reported sector is the start sector plus one, even past end-of-track.
- R4: With cmd_mt = 1, a strobe that makes the 0-based sector equal to cmd_eot ends the transfer. The sector becomes 0 and the head toggles. The cylinder increments only if the head was 1.
- R5: With cmd_mt = 1, if a strobe makes the 0-based sector reach trk_sectors without matching cmd_eot, the sector becomes 0 and the head toggles. The transfer continues (xfer_req stays 1).
- R6: Result byte 3 is drive_cyl as captured when the command was taken, even if the cylinder has since advanced.
- R7: The result bytes appear in this order: status 0, status 1 (0x00), status 2 (0x00), cylinder, head, sector + 1, size code. Each byte holds stable while res_valid is high and res_ready is low.
- R8: done is a one-cycle pulse in the first result-phase cycle. irq rises with it only if dor_dma_irq_en (bit 3 of the digital-output register) was 1 at the terminating edge. irq falls when the seventh byte is taken.
- R9: A cmd_valid that arrives while busy is ignored and does not change the pending result.
- R10: A sec_done strobe that arrives while idle or in the result phase has no effect.
- R11: Status 0 on a normal end is 0x00 with the final head in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_mt | input | 1 | Multi-track flag |
| cmd_cyl | input | 8 | Expected cylinder |
| cmd_head | input | 1 | Start head |
| cmd_sector | input | 8 | Start sector, 1-based |
| cmd_size | input | 8 | Size code, echoed in the result |
| cmd_eot | input | 8 | End-of-track sector number |
| trk_sectors | input | 8 | Sectors per track of the medium |
| drive_cyl | input | 8 | Cylinder the drive is currently on |
| dor_dma_irq_en | input | 1 | DMA/IRQ enable bit of the digital-output register |
| sec_done | input | 1 | One sector transferred |
| res_ready | input | 1 | Consumer takes the current result byte |
| busy | output | 1 | Command in progress |
| xfer_req | output | 1 | Transfer phase active |
| done | output | 1 | Result phase entered (pulse) |
| irq | output | 1 | Interrupt request |
| res_valid | output | 1 | Result byte valid |
| res_data | output | 8 | Result byte |

## Verification
The bench aims at the boundaries where the position arithmetic is easy to get wrong:

- End-of-track on head 1 must advance the cylinder while the reported cylinder stays at its captured value. A design that reports the live cylinder shows one too many.
- A track wrap before end-of-track must toggle the head and keep the transfer running. A design that stops there ends early with the wrong sector.
- A single-track command that starts on the last sector must report one past end-of-track, not wrap.
- A stalled handshake must keep each result byte stable, and a cylinder mismatch must skip the transfer entirely.

Stray commands and strobes are thrown at the busy and idle phases, and the result bytes show whether any of them leaked in.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;
  localparam int unsigned FB = 8;
  typedef logic [FB-1:0] fbyte_t;

  typedef enum logic [1:0] {SQ_IDLE = 2'd0, SQ_XFER = 2'd1, SQ_RSLT = 2'd2} sq_state_t;

  typedef struct packed {
    fbyte_t cyl;
    logic   head;
    fbyte_t sec;
  } fpos_t;

  typedef struct packed {
    fpos_t pos;
    logic  stop;
    logic  eot_hit;
    logic  trk_wrap;
  } fstep_t;

  // Position after one sector; sec is 0-based.
  function automatic fstep_t advance(fpos_t p, logic mt, fbyte_t eot, fbyte_t spt);
    fstep_t r;
    fbyte_t s;
    s          = p.sec + 1'b1;
    r.pos      = p;
    r.stop     = 1'b0;
    r.eot_hit  = 1'b0;
    r.trk_wrap = 1'b0;
    if (!mt) begin
      r.pos.sec = s;
      r.stop    = 1'b1;
    end else if (s == eot) begin
      r.pos.sec  = '0;
      if (p.head) r.pos.cyl = p.cyl + 1'b1;
      r.pos.head = ~p.head;
      r.stop     = 1'b1;
      r.eot_hit  = 1'b1;
    end else if (s >= spt) begin
      r.pos.sec  = '0;
      r.pos.head = ~p.head;
      r.trk_wrap = 1'b1;
    end else begin
      r.pos.sec = s;
    end
    return r;
  endfunction

  function automatic fbyte_t status0(logic abnormal, logic head);
    fbyte_t v;
    v    = '0;
    v[6] = abnormal;
    v[2] = head;
    return v;
  endfunction
endpackage

// File: rtl/fdc_pos_step.sv
module fdc_pos_step
  import fdc_seq_pkg::*;
(
  input  fpos_t  cur,
  input  logic   mt,
  input  fbyte_t eot,
  input  fbyte_t spt,
  output fpos_t  nxt,
  output logic   stop,
  output logic   eot_hit,
  output logic   trk_wrap
);
  fstep_t st;

  always_comb begin
    st       = advance(cur, mt, eot, spt);
    nxt      = st.pos;
    stop     = st.stop;
    eot_hit  = st.eot_hit;
    trk_wrap = st.trk_wrap;
  end
endmodule

// File: rtl/fdc_result_sel.sv
module fdc_result_sel
  import fdc_seq_pkg::*;
#(
  parameter int unsigned N_RES = 7,
  localparam int unsigned IDX_W = $clog2(N_RES)
) (
  input  logic [IDX_W-1:0] idx,
  input  fbyte_t           st0,
  input  fbyte_t           cyl,
  input  logic             head,
  input  fbyte_t           sec,
  input  fbyte_t           size,
  output fbyte_t           bval,
  output logic             last
);
  always_comb begin
    case (idx)
      3'd0:    bval = st0;
      3'd3:    bval = cyl;
      3'd4:    bval = fbyte_t'(head);
      3'd5:    bval = sec + 1'b1;
      3'd6:    bval = size;
      default: bval = '0;
    endcase
    last = (idx == IDX_W'(N_RES - 1));
  end
endmodule

// File: rtl/fdc_xfer_seq.sv
module fdc_xfer_seq
  import fdc_seq_pkg::*;
#(
  parameter int unsigned N_RES = 7,
  localparam int unsigned IDX_W = $clog2(N_RES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       cmd_mt,
  input  logic [7:0] cmd_cyl,
  input  logic       cmd_head,
  input  logic [7:0] cmd_sector,
  input  logic [7:0] cmd_size,
  input  logic [7:0] cmd_eot,
  input  logic [7:0] trk_sectors,
  input  logic [7:0] drive_cyl,
  input  logic       dor_dma_irq_en,
  input  logic       sec_done,
  input  logic       res_ready,
  output logic       busy,
  output logic       xfer_req,
  output logic       done,
  output logic       irq,
  output logic       res_valid,
  output logic [7:0] res_data
);
  sq_state_t        st;
  fpos_t            pos_q, pos_nxt;
  fbyte_t           start_cyl_q, eot_q, spt_q, size_q, st0_q;
  logic             mt_q, done_q, irq_q;
  logic [IDX_W-1:0] idx_q;
  logic             step_stop, eot_evt, wrap_evt, last_byte;

  // Named internal events
  logic accept, cyl_miss, step_evt, term_evt, last_take;

  fdc_pos_step u_step (
    .cur(pos_q), .mt(mt_q), .eot(eot_q), .spt(spt_q),
    .nxt(pos_nxt), .stop(step_stop), .eot_hit(eot_evt), .trk_wrap(wrap_evt)
  );

  fdc_result_sel #(.N_RES(N_RES)) u_rsel (
    .idx(idx_q), .st0(st0_q), .cyl(start_cyl_q), .head(pos_q.head),
    .sec(pos_q.sec), .size(size_q), .bval(res_data), .last(last_byte)
  );

  always_comb begin
    accept    = (st == SQ_IDLE) && cmd_valid;
    cyl_miss  = (drive_cyl != cmd_cyl);
    step_evt  = (st == SQ_XFER) && sec_done;
    term_evt  = (accept && cyl_miss) || (step_evt && step_stop);
    last_take = (st == SQ_RSLT) && res_ready && last_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= SQ_IDLE;
      pos_q       <= '0;
      start_cyl_q <= '0;
      eot_q       <= '0;
      spt_q       <= '0;
      size_q      <= '0;
      st0_q       <= '0;
      mt_q        <= 1'b0;
      idx_q       <= '0;
      done_q      <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      done_q <= term_evt;
      if (term_evt)       irq_q <= dor_dma_irq_en;
      else if (last_take) irq_q <= 1'b0;
      case (st)
        SQ_IDLE: if (accept) begin
          pos_q.cyl   <= drive_cyl;
          pos_q.head  <= cmd_head;
          pos_q.sec   <= cmd_sector - 8'd1;
          start_cyl_q <= drive_cyl;
          mt_q        <= cmd_mt;
          eot_q       <= cmd_eot;
          spt_q       <= trk_sectors;
          size_q      <= cmd_size;
          idx_q       <= '0;
          if (cyl_miss) begin
            st    <= SQ_RSLT;
            st0_q <= status0(1'b1, cmd_head);
          end else begin
            st <= SQ_XFER;
          end
        end
        SQ_XFER: if (step_evt) begin
          pos_q <= pos_nxt;
          if (step_stop) begin
            st    <= SQ_RSLT;
            st0_q <= status0(1'b0, pos_nxt.head);
          end
        end
        SQ_RSLT: if (res_ready) begin
          if (last_byte) st <= SQ_IDLE;
          else           idx_q <= idx_q + 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (st != SQ_IDLE);
  assign xfer_req  = (st == SQ_XFER);
  assign res_valid = (st == SQ_RSLT);
  assign done      = done_q;
  assign irq       = irq_q;

  // Assertions
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !irq && !done));

  p_miss_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cyl_miss) |=> (res_valid && res_data[6] && done));

  p_single_sector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !mt_q) |=> (st == SQ_RSLT));

  p_eot_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && eot_evt) |=> (res_valid && pos_q.sec == 8'd0));

  p_wrap_continues_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && wrap_evt) |=> (xfer_req && pos_q.sec == 8'd0));

  p_start_cyl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(start_cyl_q));

  p_byte_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(dor_dma_irq_en) && done));

  p_stray_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SQ_XFER && !accept) |=> $stable(pos_q));
endmodule

// File: tb/fdc_xfer_seq_bench.sv
module fdc_xfer_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_mt = 1'b0, cmd_head = 1'b0;
  logic [7:0] cmd_cyl = '0, cmd_sector = 8'd1, cmd_size = '0, cmd_eot = '0;
  logic [7:0] trk_sectors = 8'd18, drive_cyl = '0;
  logic       dor_dma_irq_en = 1'b0, sec_done = 1'b0, res_ready = 1'b0;
  logic       busy, xfer_req, done, irq, res_valid;
  logic [7:0] res_data;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] got_q[$];

  always #5 clk = ~clk;

  fdc_xfer_seq u_fdc_xfer_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mt(cmd_mt),
    .cmd_cyl(cmd_cyl), .cmd_head(cmd_head), .cmd_sector(cmd_sector),
    .cmd_size(cmd_size), .cmd_eot(cmd_eot), .trk_sectors(trk_sectors),
    .drive_cyl(drive_cyl), .dor_dma_irq_en(dor_dma_irq_en), .sec_done(sec_done),
    .res_ready(res_ready), .busy(busy), .xfer_req(xfer_req), .done(done),
    .irq(irq), .res_valid(res_valid), .res_data(res_data)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, updated at each rising edge
  int m_st = 0, m_sec = 0, m_head = 0, m_cyl = 0, m_start = 0, m_mt = 0;
  int m_eot = 0, m_spt = 0, m_size = 0, m_st0 = 0, m_idx = 0, m_done = 0, m_irq = 0;

  function automatic int model_byte();
    case (m_idx)
      0: return m_st0;
      3: return m_start;
      4: return m_head;
      5: return (m_sec + 1) % 256;
      6: return m_size;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_done = 0; m_irq = 0; m_idx = 0;
    end else begin
      int fin;
      fin = 0;
      m_done = 0;
      if (m_st == 0) begin
        if (cmd_valid) begin
          m_cyl = drive_cyl; m_start = drive_cyl; m_head = cmd_head;
          m_sec = (cmd_sector + 255) % 256; m_mt = cmd_mt; m_eot = cmd_eot;
          m_spt = trk_sectors; m_size = cmd_size;
          if (drive_cyl != cmd_cyl) begin
            m_st = 2; m_st0 = 8'h40 + m_head * 4; m_done = 1;
            m_irq = dor_dma_irq_en; m_idx = 0;
          end else m_st = 1;
        end
      end else if (m_st == 1) begin
        if (sec_done) begin
          int s;
          s = (m_sec + 1) % 256;
          if (m_mt == 0) begin m_sec = s; fin = 1; end
          else if (s == m_eot) begin
            m_sec = 0;
            if (m_head == 1) m_cyl = (m_cyl + 1) % 256;
            m_head = 1 - m_head; fin = 1;
          end else if (s >= m_spt) begin m_sec = 0; m_head = 1 - m_head; end
          else m_sec = s;
          if (fin == 1) begin
            m_st = 2; m_st0 = m_head * 4; m_done = 1; m_irq = dor_dma_irq_en; m_idx = 0;
          end
        end
      end else begin
        if (res_ready) begin
          if (m_idx == 6) begin m_st = 0; m_irq = 0; end
          else m_idx++;
        end
      end
    end
  end

  // Mid-cycle compare and capture of handshake transfers
  always @(negedge clk) begin
    chk("R1/R9 busy", busy, m_st != 0);
    chk("R3/R5 xfer_req", xfer_req, m_st == 1);
    chk("R8 done", done, m_done);
    chk("R8 irq", irq, m_irq);
    chk("R7 res_valid", res_valid, m_st == 2);
    if (m_st == 2) chk("R7 res_data", res_data, model_byte());
    if (rst_n && res_valid && res_ready) got_q.push_back(res_data);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic issue(bit mt, int cyl, bit hd, int sec, int sz, int eot, int spt, int dcyl);
    @(posedge clk); #4;
    cmd_mt = mt; cmd_cyl = 8'(cyl); cmd_head = hd; cmd_sector = 8'(sec);
    cmd_size = 8'(sz); cmd_eot = 8'(eot); trk_sectors = 8'(spt); drive_cyl = 8'(dcyl);
    cmd_valid = 1'b1;
    @(posedge clk); #4;
    cmd_valid = 1'b0;
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #4; sec_done = 1'b1;
      @(posedge clk); #4; sec_done = 1'b0;
    end
  endtask

  task automatic wait_result();
    int k;
    k = 0;
    do begin @(negedge clk); k++; end while (!res_valid && k < 100);
  endtask

  task automatic drain(int stall);
    got_q.delete();
    for (int k = 0; k < 200; k++) begin
      @(posedge clk); #4;
      if (got_q.size() >= 7) break;
      res_ready = (stall == 0) || ((k % 3) != 1);
    end
    res_ready = 1'b0;
  endtask

  task automatic expect_res(string tag, int s0, int c, int h, int r, int n);
    int exp[7];
    exp = '{s0, 0, 0, c, h, r, n};
    chk({tag, " count"}, got_q.size(), 7);
    for (int i = 0; i < 7 && i < got_q.size(); i++)
      chk($sformatf("%s byte%0d", tag, i), got_q[i], exp[i]);
  endtask

  initial begin
    logic [7:0] a;
    repeat (3) @(posedge clk);
    #4 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 res_valid after reset", res_valid, 0);

    // R2: cylinder mismatch, IRQ enabled, stalled handshake (R7)
    dor_dma_irq_en = 1'b1;
    issue(1'b1, 7, 1'b1, 3, 2, 18, 18, 5);
    @(negedge clk);
    chk("R2 result immediate", res_valid, 1);
    chk("R2 no transfer", xfer_req, 0);
    chk("R8 done pulse", done, 1);
    chk("R8 irq enabled", irq, 1);
    a = res_data;
    @(negedge clk);
    chk("R7 held while stalled", res_data, a);
    chk("R8 done one cycle", done, 0);
    drain(1);
    expect_res("R2 mismatch", 8'h44, 5, 1, 3, 2);
    @(negedge clk);
    chk("R8 irq cleared after last byte", irq, 0);

    // R10: stray strobes while idle
    dor_dma_irq_en = 1'b0;
    strobe(2);
    @(negedge clk);
    chk("R10 idle strobe busy", busy, 0);

    // R3: single-track, one sector
    issue(1'b0, 2, 1'b0, 4, 1, 18, 18, 2);
    @(negedge clk);
    chk("R3 transfer requested", xfer_req, 1);
    strobe(1);
    wait_result();
    chk("R8 irq gated off", irq, 0);
    strobe(1);  // R10 strobe during result phase
    drain(0);
    expect_res("R3 single", 8'h00, 2, 0, 5, 1);

    // R3 corner: single-track starting on end-of-track sector
    issue(1'b0, 6, 1'b1, 18, 2, 18, 18, 6);
    strobe(1);
    wait_result();
    drain(0);
    expect_res("R3 past eot", 8'h04, 6, 1, 19, 2);

    // R4: multi-track end-of-track on head 0
    dor_dma_irq_en = 1'b1;
    issue(1'b1, 4, 1'b0, 17, 2, 18, 18, 4);
    strobe(2);
    wait_result();
    drain(0);
    expect_res("R4 eot head0 R11", 8'h04, 4, 1, 1, 2);

    // R4/R6: end-of-track on head 1 advances cylinder, report keeps start
    issue(1'b1, 3, 1'b1, 18, 3, 18, 18, 3);
    strobe(1);
    wait_result();
    drain(1);
    expect_res("R6 latched cyl", 8'h00, 3, 0, 1, 3);

    // R5 + R9: track wrap before end-of-track, stray command while busy
    issue(1'b1, 9, 1'b0, 7, 2, 3, 8, 9);
    strobe(2);
    @(negedge clk);
    chk("R5 continues after wrap", xfer_req, 1);
    issue(1'b0, 1, 1'b1, 1, 0, 1, 1, 0);
    @(negedge clk);
    chk("R9 still transferring", xfer_req, 1);
    strobe(3);
    wait_result();
    drain(0);
    expect_res("R5 wrap R9", 8'h00, 9, 0, 1, 2);

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule